// File: doc/BRIEF.md
# PHY Management Serial Master

This block runs single read and write accesses to the management registers of an external Ethernet PHY over a two-wire serial link. One wire is a clock. The other is a shared bidirectional data line. The host presents one command in a single cycle. The command holds a direction flag, a 5-bit PHY address, a 5-bit register address and a 16-bit write value. The block then serialises a fixed-layout frame and reports completion with a one-cycle pulse. For a read, it also returns the 16 bits that the PHY sent back.

The management clock is made from the system clock. Its high phase and its low phase each last a programmable number of system clocks, so the divisor is always even and at least 2. Between accesses the management clock rests low. The data line reaches the pad as a value plus an output enable, and the pad is driven only while that enable is high. The master hands the line to the PHY for the turnaround and data fields of a read. A mode input drops the 32-bit preamble of ones, so the frame begins directly at the start field.

Top module: `mdio_master`

## Requirements
- R1: While and after reset, `busy`, `done`, `mdc`, `mdio_oe` are 0 and `rd_data` is 16'h0000.
- R2: With `no_preamble` low, a frame is 64 bits, sent most significant first, in this order: 32 ones, the start pair 0 then 1, the opcode (1,0 for a read; 0,1 for a write), the PHY address MSB first, then the register address MSB first.
- R3: With `no_preamble` high, the 32 preamble bits are omitted and the frame is 32 MDC cycles long, beginning with the start pair.
- R4: On a write, the turnaround field is driven as 1 then 0 and is followed by the 16 write bits, MSB first. `mdio_oe` is high for every bit of the frame.
- R5: On a read, `mdio_oe` is low for both turnaround bits and all 16 data bits. The 16 values of `mdio_i` sampled at the MDC rising edges of the data field, first one as MSB, appear on `rd_data` when `done` pulses.
- R6: The MDC high phase and the MDC low phase each last `div_half` system clocks, with `div_half` = 0 treated as 1. The value is captured when the command is accepted. `mdc` is low whenever `busy` is low.
- R7: `mdio_o` and `mdio_oe` change only at falling MDC edges (or at command acceptance), so both are stable while `mdc` is high.
- R8: A command is taken when `cmd_valid` is high and `busy` is low. `busy` stays high until completion. Commands presented while busy are ignored and produce neither a frame nor a `done`.
- R9: `done` is high for exactly one cycle, 2*H*N system clocks after the acceptance edge, where H is the effective half period and N is the frame length (64 or 32). `busy` falls on that same edge.
- R10: A write leaves `rd_data` holding the previous read result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command request |
| cmd_read | input | 1 | 1 = read access, 0 = write access |
| cmd_phy | input | 5 | PHY address |
| cmd_reg | input | 5 | Register address |
| cmd_wdata | input | 16 | Write value |
| no_preamble | input | 1 | Omit the 32-bit preamble |
| div_half | input | DIV_W | MDC half period in system clocks (0 acts as 1) |
| rd_data | output | 16 | Result of the latest read |
| busy | output | 1 | Access in progress |
| done | output | 1 | One-cycle completion pulse |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Data line value toward the pad |
| mdio_oe | output | 1 | Data line drive enable |
| mdio_i | input | 1 | Data line value from the pad |

## Verification
The completion pulse is due 2*H*N system clocks after the acceptance edge. The bench records the cycle count of the acceptance edge and compares it with the count at the edge where `done` is sampled high. Each frame bit is due at an MDC rising edge, so a model on the bench side captures the line value there and advances its own bit index. From that index it computes the read reply it must present, independently of the design, and each captured sequence is compared when the pulse arrives. The read result is due on the same pulse edge. The MDC high phase is measured in system clocks for every bit and must equal the effective half period.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int FRAME_LEN = 64;
  localparam int PRE_LEN   = 32;
  localparam int POS_W     = 6;
  localparam int TA_POS    = 46;
  localparam int DATA_POS  = 48;

  // Frame laid out MSB first: preamble, start, opcode, phy, reg, turnaround, data
  function automatic logic [FRAME_LEN-1:0] build_frame(input logic rd,
                                                       input logic [4:0] phy,
                                                       input logic [4:0] rg,
                                                       input logic [15:0] wd);
    logic [1:0]  op;
    logic [1:0]  ta;
    logic [15:0] dat;
    op  = rd ? 2'b10 : 2'b01;
    ta  = rd ? 2'b11 : 2'b10;
    dat = rd ? 16'hFFFF : wd;
    return {{PRE_LEN{1'b1}}, 2'b01, op, phy, rg, ta, dat};
  endfunction

  function automatic logic [POS_W-1:0] first_pos(input logic nopre);
    return nopre ? POS_W'(PRE_LEN) : '0;
  endfunction

  function automatic logic master_drives(input logic rd, input logic [POS_W-1:0] pos);
    return !(rd && (pos >= POS_W'(TA_POS)));
  endfunction

  function automatic logic in_data(input logic [POS_W-1:0] pos);
    return pos >= POS_W'(DATA_POS);
  endfunction

  function automatic logic is_last(input logic [POS_W-1:0] pos);
    return pos == POS_W'(FRAME_LEN - 1);
  endfunction
endpackage

// File: rtl/mdio_clk_div.sv
module mdio_clk_div #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             run,
  input  logic [DIV_W-1:0] half_in,
  output logic             mdc,
  output logic             rise_evt,
  output logic             fall_evt
);
  logic [DIV_W-1:0] half_q;
  logic [DIV_W-1:0] cnt;
  logic             wrap;

  assign wrap     = run && (cnt == half_q - DIV_W'(1));
  assign rise_evt = wrap && !mdc;
  assign fall_evt = wrap && mdc;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      half_q <= DIV_W'(1);
    end else if (start) begin
      half_q <= (half_in == '0) ? DIV_W'(1) : half_in;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (!run) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (wrap) begin
      cnt <= '0;
      mdc <= ~mdc;
    end else begin
      cnt <= cnt + DIV_W'(1);
    end
  end
endmodule

// File: rtl/mdio_tx_seq.sv
module mdio_tx_seq
  import mdio_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             nopre,
  input  logic             rd,
  input  logic [4:0]       phy,
  input  logic [4:0]       rg,
  input  logic [15:0]      wd,
  input  logic             fall_evt,
  output logic             mdio_o,
  output logic             mdio_oe,
  output logic [POS_W-1:0] pos,
  output logic             last_bit,
  output logic             is_read
);
  logic [FRAME_LEN-1:0] shreg;
  logic [FRAME_LEN-1:0] frame_new;
  logic                 active;

  assign frame_new = build_frame(rd, phy, rg, wd);
  assign last_bit  = is_last(pos);
  assign mdio_o    = active & shreg[FRAME_LEN-1];
  assign mdio_oe   = active & master_drives(is_read, pos);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shreg   <= '0;
      pos     <= '0;
      active  <= 1'b0;
      is_read <= 1'b0;
    end else if (start) begin
      shreg   <= nopre ? {frame_new[FRAME_LEN-PRE_LEN-1:0], {PRE_LEN{1'b0}}} : frame_new;
      pos     <= first_pos(nopre);
      active  <= 1'b1;
      is_read <= rd;
    end else if (fall_evt) begin
      if (last_bit) begin
        active <= 1'b0;
      end else begin
        shreg <= {shreg[FRAME_LEN-2:0], 1'b0};
        pos   <= pos + POS_W'(1);
      end
    end
  end
endmodule

// File: rtl/mdio_rx_cap.sv
module mdio_rx_cap
  import mdio_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rise_evt,
  input  logic             finish,
  input  logic             is_read,
  input  logic [POS_W-1:0] pos,
  input  logic             mdio_i,
  output logic [15:0]      rd_data
);
  logic [15:0] sh;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh      <= '0;
      rd_data <= '0;
    end else begin
      if (rise_evt && is_read && in_data(pos)) sh <= {sh[14:0], mdio_i};
      if (finish && is_read) rd_data <= sh;
    end
  end
endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdio_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  input  logic             cmd_read,
  input  logic [4:0]       cmd_phy,
  input  logic [4:0]       cmd_reg,
  input  logic [15:0]      cmd_wdata,
  input  logic             no_preamble,
  input  logic [DIV_W-1:0] div_half,
  output logic [15:0]      rd_data,
  output logic             busy,
  output logic             done,
  output logic             mdc,
  output logic             mdio_o,
  output logic             mdio_oe,
  input  logic             mdio_i
);
  logic             accept_evt;
  logic             finish_evt;
  logic             rise_evt;
  logic             fall_evt;
  logic             last_bit;
  logic             is_read;
  logic [POS_W-1:0] pos;

  assign accept_evt = cmd_valid && !busy;
  assign finish_evt = busy && fall_evt && last_bit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      done <= 1'b0;
    end else begin
      done <= finish_evt;
      if (accept_evt)      busy <= 1'b1;
      else if (finish_evt) busy <= 1'b0;
    end
  end

  mdio_clk_div #(.DIV_W(DIV_W)) u_div (
    .clk(clk), .rst_n(rst_n), .start(accept_evt), .run(busy),
    .half_in(div_half), .mdc(mdc), .rise_evt(rise_evt), .fall_evt(fall_evt)
  );

  mdio_tx_seq u_tx (
    .clk(clk), .rst_n(rst_n), .start(accept_evt), .nopre(no_preamble),
    .rd(cmd_read), .phy(cmd_phy), .rg(cmd_reg), .wd(cmd_wdata),
    .fall_evt(fall_evt), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
    .pos(pos), .last_bit(last_bit), .is_read(is_read)
  );

  mdio_rx_cap u_rx (
    .clk(clk), .rst_n(rst_n), .rise_evt(rise_evt), .finish(finish_evt),
    .is_read(is_read), .pos(pos), .mdio_i(mdio_i), .rd_data(rd_data)
  );
endmodule

// File: rtl/mdio_master_chk.sv
module mdio_master_chk (
  input logic clk,
  input logic rst_n,
  input logic busy,
  input logic done,
  input logic mdc,
  input logic mdio_o,
  input logic mdio_oe,
  input logic accept_evt,
  input logic fall_evt
);
  a_r6_mdc_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mdc);
  a_r1_no_drive_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mdio_oe);
  a_r7_stable_high: assert property (@(posedge clk) disable iff (!rst_n)
    (mdc && $past(mdc)) |-> ($stable(mdio_o) && $stable(mdio_oe)));
  a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r9_done_after_fall: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(fall_evt));
  a_r8_busy_ends_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);
  a_r8_accept_sets_busy: assert property (@(posedge clk) disable iff (!rst_n)
    accept_evt |=> busy);
endmodule

bind mdio_master mdio_master_chk u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .mdc(mdc),
  .mdio_o(mdio_o), .mdio_oe(mdio_oe), .accept_evt(accept_evt), .fall_evt(fall_evt)
);

// File: tb/mdio_master_test.sv
`timescale 1ns/1ps
module mdio_master_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic        cmd_valid = 0, cmd_read = 0, no_preamble = 0;
  logic [4:0]  cmd_phy = 0, cmd_reg = 0;
  logic [15:0] cmd_wdata = 0;
  logic [7:0]  div_half = 8'd1;
  logic [15:0] rd_data;
  logic        busy, done, mdc, mdio_o, mdio_oe, mdio_i;

  mdio_master uut (.*);

  int total = 0, bad = 0;
  longint cyc = 0, t0 = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct {
    logic [63:0] frame; logic [63:0] oe; int nbits;
    logic [15:0] rd; longint elapsed; int half;
  } exp_t;
  exp_t q[$];

  logic [15:0] resp = 0, last_read = 0;
  logic        cur_nopre = 0;
  int          rc = 0, nb = 0, hic = 0, hmin = 1000, hmax = 0;
  logic [63:0] got = 0, oeg = 0;
  logic        phy_drive, prev_done = 0;

  always_comb begin
    int p;
    p = (cur_nopre ? 32 : 0) + rc;
    phy_drive = (p >= 48 && p <= 63) ? resp[63-p] : 1'b1;
  end
  assign mdio_i = phy_drive;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // PHY side: capture the line at each MDC rising edge
  always @(posedge mdc) begin
    got = {got[62:0], (mdio_oe ? mdio_o : phy_drive)};
    oeg = {oeg[62:0], mdio_oe};
    nb++;
    rc++;
  end

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (mdc) hic++;
      else if (hic != 0) begin
        if (hic < hmin) hmin = hic;
        if (hic > hmax) hmax = hic;
        hic = 0;
      end
      if (done && prev_done) chk(0, "R9", "done wider than one cycle", 1, 0);
      if (done) begin
        if (q.size() == 0) chk(0, "R8", "unexpected done", 1, 0);
        else begin
          exp_t e;
          logic [63:0] m;
          e = q.pop_front();
          m = (e.nbits == 64) ? {64{1'b1}} : {32'h0, {32{1'b1}}};
          chk(nb == e.nbits, "R3", "frame length", nb, e.nbits);
          chk((got & m) == (e.frame & m), "R2", "frame bits", got & m, e.frame & m);
          chk((oeg & m) == (e.oe & m), "R5", "drive enable per bit", oeg & m, e.oe & m);
          chk(cyc - t0 == e.elapsed, "R9", "done latency", cyc - t0, e.elapsed);
          chk(rd_data == e.rd, "R10", "rd_data at done", rd_data, e.rd);
          chk(hmin == e.half && hmax == e.half, "R6", "mdc high phase", hmax, e.half);
          chk(!busy, "R9", "busy low with done", busy, 0);
        end
      end
      prev_done = done;
    end
  end

  task automatic issue(input logic rd, input logic [4:0] phy, input logic [4:0] rg,
                       input logic [15:0] wd, input logic [15:0] rsp,
                       input logic nopre, input logic [7:0] half, input bit poke);
    exp_t e;
    int h;
    h = (half == 0) ? 1 : int'(half);
    e.frame = {32'hFFFF_FFFF, 2'b01, (rd ? 2'b10 : 2'b01), phy, rg,
               (rd ? 2'b11 : 2'b10), (rd ? rsp : wd)};
    e.oe    = rd ? {{46{1'b1}}, 18'h0} : {64{1'b1}};
    e.nbits = nopre ? 32 : 64;
    e.half  = h;
    e.elapsed = longint'(2 * h * e.nbits);
    if (rd) last_read = rsp;
    e.rd = last_read;
    q.push_back(e);
    @(negedge clk);
    resp = rsp; cur_nopre = nopre; rc = 0; nb = 0; got = 0; oeg = 0;
    hmin = 1000; hmax = 0; hic = 0;
    cmd_read = rd; cmd_phy = phy; cmd_reg = rg; cmd_wdata = wd;
    no_preamble = nopre; div_half = half; cmd_valid = 1;
    @(posedge clk); #1 t0 = cyc;
    @(negedge clk); cmd_valid = 0;
    if (poke) begin
      // R8: a second command while busy must be ignored
      repeat (10) @(negedge clk);
      cmd_read = ~rd; cmd_phy = ~phy; cmd_reg = ~rg; cmd_wdata = ~wd;
      no_preamble = ~nopre; div_half = 8'd3; cmd_valid = 1;
      repeat (4) @(negedge clk);
      cmd_valid = 0;
    end
    while (busy) @(negedge clk);
    repeat (4) @(negedge clk);
    chk(!mdc && !busy && !mdio_oe, "R6", "idle after access", {mdc, busy, mdio_oe}, 0);
    chk(q.size() == 0, "R8", "pending expected items", q.size(), 0);
  endtask

  initial begin
    #(8 * 20000);
    total++; bad++;
    $display("FAIL R9 watchdog: actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    chk(!busy && !done && !mdc && !mdio_oe && rd_data == 0, "R1", "reset state",
        {busy, done, mdc, mdio_oe, rd_data}, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);
    chk(!busy && !done && !mdc && !mdio_oe && rd_data == 0, "R1", "after reset",
        {busy, done, mdc, mdio_oe, rd_data}, 0);
    issue(0, 5'h11, 5'h04, 16'hA5C3, 16'h0,    0, 8'd2, 0); // R2 R4 write
    issue(1, 5'h1F, 5'h00, 16'h0,    16'h8001, 0, 8'd1, 0); // R5 read
    issue(0, 5'h00, 5'h1F, 16'h0F0F, 16'h0,    1, 8'd3, 0); // R3 R10
    issue(1, 5'h0A, 5'h15, 16'h0,    16'h7E5A, 1, 8'd0, 0); // R6 zero half
    issue(0, 5'h03, 5'h09, 16'h1234, 16'h0,    0, 8'd1, 1); // R8 poke while busy
    issue(1, 5'h15, 5'h0A, 16'h0,    16'hC0DE, 0, 8'd4, 0); // R5 R6 long half
    chk(rd_data == 16'hC0DE, "R5", "final read value", rd_data, 16'hC0DE);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule